// File: doc/BRIEF.md
# Serial Command Decoder for a Digital Resistor Setting

This block is the serial front end of a single-channel digital resistor. A host drives chip select low, clocks command bytes in on the data input with the serial clock, and reads status and register contents back on the data output. Each command opens with one byte that names a register and an operation. Write and read commands add a second byte, giving a 9-bit value. Increment and decrement commands are one byte long. Several commands may follow each other inside one chip-select window.

The block holds two 9-bit registers: the wiper setting and a control register. It checks every address and operation pair as soon as the pair has arrived. An illegal pair is reported on the data output. The interface then goes deaf until chip select is released. Nothing executes before its last clock, so a command cut short by chip-select release is dropped.

The serial pins are oversampled by the system clock through synchronizers. The serial clock must therefore run several times slower than the system clock.

Top module: `rheo_spi_decoder`

## Requirements
- R1: After reset the wiper register holds 080h, the control register holds 1FFh, and the data-output enable is low.
- R2: A command byte is taken MSB first as address[3:0], operation[1:0], a spare bit, then data bit 8. Data is sampled on the rising serial-clock edge. Operation 00 (write) to address 0h takes a second byte as data bits 7..0 and loads the wiper after the 16th clock.
- R3: Operation 01 (increment) and operation 10 (decrement) to address 0h are one byte long. They execute after the 8th clock. Increment stops at 100h and decrement stops at 000h.
- R4: Operation 11 (read) returns the addressed 9-bit register on the data output, bit 8 in the 8th bit slot and bits 7..0 in slots 9 to 16, MSB first. No register changes.
- R5: Address 4h is the control register. It accepts write and read only. It stores all 9 written bits, and the spare bit has no effect.
- R6: The output changes on the falling serial-clock edge. It reads 1 in slots 1 to 6 and in every data slot of a non-read command. In slot 7 it reads 1 for a legal pair. An illegal pair drives 0 in slot 7 and in every later slot of the window. Legal pairs are address 0h with any operation, and address 4h with write or read.
- R7: After an illegal pair, all later commands in the same window are ignored. Releasing chip select clears the error, and the next window works normally.
- R8: A command whose clock count is cut short by chip-select release is discarded, and the next window starts at bit 0.
- R9: Commands sent back to back in one window each execute in order.
- R10: While chip select is high, serial-clock and data activity is ignored and the output enable is low.
- R11: A wiper write of any value at or above 100h stores 100h (full scale).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_sdi | input | 1 | Serial data in |
| spi_sdo | output | 1 | Serial data out |
| spi_sdo_oe | output | 1 | Output enable for the serial data out (low = high impedance) |
| wiper_o | output | 9 | Current wiper setting |
| ctrl_o | output | 9 | Current control register |

## Verification
Some properties are checked on every cycle:
- the wiper never rises above full scale;
- an increment adds exactly one and a decrement at zero stays at zero;
- once an error is latched, every following output bit is low and no register update is issued;
- while chip select has been idle, the wiper does not move.

Other behaviour only the bench scenarios can show:
- the bit order of commands and readback;
- saturation reached through a sequence of commands;
- dropping of truncated commands;
- back-to-back execution in one window;
- clearing of the lockout when a new window opens.

// File: rtl/rheo_spi_pkg.sv
package rheo_spi_pkg;
  localparam int ADDR_W     = 4;
  localparam int OP_W       = 2;
  localparam int DATA_W     = 9;
  localparam int SHORT_BITS = 8;
  localparam int LONG_BITS  = 16;
  localparam int CNT_W      = $clog2(LONG_BITS);
  localparam int SHIFT_W    = DATA_W - 1;

  typedef enum logic [OP_W-1:0] {
    OP_WRITE = 2'b00,
    OP_INC   = 2'b01,
    OP_DEC   = 2'b10,
    OP_READ  = 2'b11
  } op_e;

  localparam logic [ADDR_W-1:0] ADDR_WIPER = 4'h0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 4'h4;

  typedef struct packed {
    logic              wr;
    logic              inc;
    logic              dec;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_req_t;

  function automatic logic pair_ok(input logic [ADDR_W-1:0] a, input op_e op);
    if (a == ADDR_WIPER) return 1'b1;
    if (a == ADDR_CTRL)  return (op == OP_WRITE) || (op == OP_READ);
    return 1'b0;
  endfunction
endpackage

// File: rtl/rheo_spi_sync.sv
module rheo_spi_sync #(
  parameter int           N       = 3,
  parameter int           STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] level_o
);
  for (genvar g = 0; g < N; g++) begin : g_chain
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= {STAGES{RST_VAL[g]}};
      else     chain_q <= {chain_q[STAGES-2:0], async_i[g]};
    end
    assign level_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/rheo_spi_frame.sv
module rheo_spi_frame
  import rheo_spi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_s,
  input  logic              sck_s,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output cmd_req_t          req_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam logic [CNT_W-1:0] DECODE_AT = CNT_W'(ADDR_W + OP_W - 1);
  localparam logic [CNT_W-1:0] SHORT_END = CNT_W'(SHORT_BITS - 1);
  localparam logic [CNT_W-1:0] LONG_END  = CNT_W'(LONG_BITS - 1);
  localparam logic [CNT_W-1:0] STATUS_AT = CNT_W'(SHORT_BITS - 1);

  logic              sck_d, cs_act, sck_rise, sck_fall;
  logic [CNT_W-1:0]  cnt_q;
  logic [SHIFT_W-1:0] sh_q;
  logic [SHIFT_W:0]  nb;
  logic              err_q, sdo_q, oe_q, ok, sdo_bit;
  logic [ADDR_W-1:0] addr_q;
  op_e               op_q;
  cmd_req_t          req_q;
  logic [CNT_W-1:0]  bidx;
  logic [LONG_BITS-1:0] rd_ext;

  assign cs_act   = ~cs_n_s;
  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign nb       = {sh_q, sdi_s};
  assign ok       = pair_ok(nb[ADDR_W+OP_W-1:OP_W], op_e'(nb[OP_W-1:0]));
  assign bidx     = LONG_END - cnt_q;
  assign rd_ext   = {{(LONG_BITS-DATA_W){1'b0}}, rd_data_i};

  always_comb begin
    if (cnt_q < STATUS_AT)      sdo_bit = 1'b1;
    else if (op_q == OP_READ)   sdo_bit = rd_ext[bidx];
    else                        sdo_bit = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d  <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      err_q  <= 1'b0;
      sdo_q  <= 1'b1;
      oe_q   <= 1'b0;
      addr_q <= '0;
      op_q   <= OP_WRITE;
      req_q  <= '0;
    end else begin
      sck_d <= sck_s;
      req_q <= '0;
      oe_q  <= cs_act;
      if (!cs_act) begin
        cnt_q <= '0;
        err_q <= 1'b0;
        sdo_q <= 1'b1;
      end else begin
        if (sck_rise && !err_q) begin
          sh_q  <= nb[SHIFT_W-1:0];
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == DECODE_AT) begin
            addr_q <= nb[ADDR_W+OP_W-1:OP_W];
            op_q   <= op_e'(nb[OP_W-1:0]);
            if (!ok) err_q <= 1'b1;
          end
          if (cnt_q == SHORT_END && (op_q == OP_INC || op_q == OP_DEC)) begin
            req_q.inc  <= (op_q == OP_INC);
            req_q.dec  <= (op_q == OP_DEC);
            req_q.addr <= addr_q;
            cnt_q      <= '0;
          end
          if (cnt_q == LONG_END) begin
            cnt_q <= '0;
            if (op_q == OP_WRITE) begin
              req_q.wr   <= 1'b1;
              req_q.addr <= addr_q;
              req_q.data <= nb;
            end
          end
        end
        if (sck_fall) sdo_q <= err_q ? 1'b0 : sdo_bit;
      end
    end
  end

  assign rd_addr_o = addr_q;
  assign req_o     = req_q;
  assign sdo_o     = sdo_q;
  assign sdo_oe_o  = oe_q;

  // R6: after the error latches, the next presented bit is low
  p_err_sdo_low_r6: assert property (@(posedge clk) disable iff (rst)
    (err_q && cs_act && sck_fall) |=> !sdo_q);
  // R7: a locked-out window issues no register update
  p_err_no_req_r7: assert property (@(posedge clk) disable iff (rst)
    err_q |=> (req_q.wr == 1'b0 && req_q.inc == 1'b0 && req_q.dec == 1'b0));
endmodule

// File: rtl/rheo_spi_regs.sv
module rheo_spi_regs
  import rheo_spi_pkg::*;
#(
  parameter logic [DATA_W-1:0] WIPER_RESET = 9'h080,
  parameter logic [DATA_W-1:0] CTRL_RESET  = 9'h1FF,
  parameter logic [DATA_W-1:0] FULL_SCALE  = 9'h100
) (
  input  logic              clk,
  input  logic              rst,
  input  cmd_req_t          req_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] wiper_o,
  output logic [DATA_W-1:0] ctrl_o
);
  logic [DATA_W-1:0] wiper_q, ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wiper_q <= WIPER_RESET;
      ctrl_q  <= CTRL_RESET;
    end else begin
      if (req_i.wr && req_i.addr == ADDR_WIPER)
        wiper_q <= (req_i.data > FULL_SCALE) ? FULL_SCALE : req_i.data;
      else if (req_i.inc && req_i.addr == ADDR_WIPER && wiper_q < FULL_SCALE)
        wiper_q <= wiper_q + 1'b1;
      else if (req_i.dec && req_i.addr == ADDR_WIPER && wiper_q != '0)
        wiper_q <= wiper_q - 1'b1;
      if (req_i.wr && req_i.addr == ADDR_CTRL)
        ctrl_q <= req_i.data;
    end
  end

  assign rd_data_o = (rd_addr_i == ADDR_CTRL) ? ctrl_q : wiper_q;
  assign wiper_o   = wiper_q;
  assign ctrl_o    = ctrl_q;

  // R11: the wiper never exceeds full scale
  p_full_scale_r11: assert property (@(posedge clk) disable iff (rst)
    wiper_q <= FULL_SCALE);
  // R3: increment below full scale moves by exactly one
  p_inc_step_r3: assert property (@(posedge clk) disable iff (rst)
    (req_i.inc && !req_i.wr && req_i.addr == ADDR_WIPER && wiper_q < FULL_SCALE)
      |=> wiper_q == $past(wiper_q) + 1'b1);
  // R3: decrement at zero stays at zero
  p_dec_floor_r3: assert property (@(posedge clk) disable iff (rst)
    (req_i.dec && !req_i.wr && wiper_q == '0) |=> wiper_q == '0);
endmodule

// File: rtl/rheo_spi_decoder.sv
module rheo_spi_decoder
  import rheo_spi_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] WIPER_RESET = 9'h080,
  parameter logic [DATA_W-1:0] CTRL_RESET  = 9'h1FF,
  parameter logic [DATA_W-1:0] FULL_SCALE  = 9'h100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_sdi,
  output logic              spi_sdo,
  output logic              spi_sdo_oe,
  output logic [DATA_W-1:0] wiper_o,
  output logic [DATA_W-1:0] ctrl_o
);
  logic [2:0]        pins_s;
  cmd_req_t          req;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;

  rheo_spi_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({spi_cs_n, spi_sck, spi_sdi}),
    .level_o (pins_s)
  );

  rheo_spi_frame u_frame (
    .clk       (clk),
    .rst       (rst),
    .cs_n_s    (pins_s[2]),
    .sck_s     (pins_s[1]),
    .sdi_s     (pins_s[0]),
    .rd_data_i (rd_data),
    .rd_addr_o (rd_addr),
    .req_o     (req),
    .sdo_o     (spi_sdo),
    .sdo_oe_o  (spi_sdo_oe)
  );

  rheo_spi_regs #(
    .WIPER_RESET (WIPER_RESET),
    .CTRL_RESET  (CTRL_RESET),
    .FULL_SCALE  (FULL_SCALE)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .req_i     (req),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .wiper_o   (wiper_o),
    .ctrl_o    (ctrl_o)
  );

  // R10: with the window closed for two cycles, the wiper holds
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!spi_sdo_oe && $past(!spi_sdo_oe)) |=> $stable(wiper_o));
endmodule

// File: tb/rheo_spi_decoder_tb.sv
`timescale 1ns/1ps
module rheo_spi_decoder_tb;
  localparam int HALF = 8;
  localparam int NV   = 11;
  // {long, frame[15:0], expected wiper[8:0]}
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 16'h0055, 9'h055},
    {1'b0, 16'h0400, 9'h056},
    {1'b0, 16'h0800, 9'h055},
    {1'b1, 16'h0100, 9'h100},
    {1'b0, 16'h0400, 9'h100},
    {1'b1, 16'h01A5, 9'h100},
    {1'b0, 16'h0800, 9'h0FF},
    {1'b1, 16'h0000, 9'h000},
    {1'b0, 16'h0800, 9'h000},
    {1'b1, 16'h00FF, 9'h0FF},
    {1'b0, 16'h0400, 9'h100}
  };

  logic clk = 0, rst = 1;
  logic spi_cs_n = 1, spi_sck = 0, spi_sdi = 0;
  logic spi_sdo, spi_sdo_oe;
  logic [8:0] wiper_o, ctrl_o;
  int n_chk = 0, n_bad = 0;
  logic [15:0] so;

  always #4 clk = ~clk;

  rheo_spi_decoder u_dut (
    .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_sdi(spi_sdi), .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe),
    .wiper_o(wiper_o), .ctrl_o(ctrl_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [15:0] w, input int n, output logic [15:0] o);
    o = '0;
    for (int i = 0; i < n; i++) begin
      spi_sdi = w[15-i];
      wait_clk(HALF);
      o[15-i] = spi_sdo;
      spi_sck = 1;
      wait_clk(HALF);
      spi_sck = 0;
    end
  endtask

  task automatic cs_open();
    spi_cs_n = 0;
    wait_clk(HALF);
  endtask

  task automatic cs_close();
    wait_clk(HALF);
    spi_cs_n = 1;
    wait_clk(2*HALF);
  endtask

  task automatic xfer(input logic [15:0] w, input int n, output logic [15:0] o);
    cs_open();
    send_bits(w, n, o);
    cs_close();
  endtask

  function automatic logic [15:0] mk(input logic [3:0] a, input logic [1:0] op,
                                     input logic spare, input logic [8:0] d);
    return {a, op, spare, d};
  endfunction

  initial begin
    logic [15:0] o2;
    logic oe_seen;
    wait_clk(5);
    rst = 0;
    wait_clk(3);
    // R1 reset state
    chk("R1 wiper", {7'b0, wiper_o}, 16'h0080);
    chk("R1 ctrl", {7'b0, ctrl_o}, 16'h01FF);
    chk("R1 oe", {15'b0, spi_sdo_oe}, 16'h0000);

    // R2 R3 R11 table walk, one command per window
    for (int i = 0; i < NV; i++) begin
      xfer(VEC[i][24:9], VEC[i][25] ? 16 : 8, so);
      chk("R2/R3/R11 table wiper", {7'b0, wiper_o}, {7'b0, VEC[i][8:0]});
      if (VEC[i][25]) chk("R6 write sdo", so, 16'hFFFF);
      else            chk("R6 short sdo", {so[15:8], 8'h00}, 16'hFF00);
    end

    // R4 read of wiper (0FFh -> now 100h), no change
    xfer(mk(4'h0, 2'b11, 1'b0, 9'h000), 16, so);
    chk("R4 read wiper", so, {7'h7F, 9'h100});
    chk("R4 wiper unchanged", {7'b0, wiper_o}, 16'h0100);

    // R5 control register write with spare bit set, then read
    xfer(mk(4'h4, 2'b00, 1'b1, 9'h03C), 16, so);
    chk("R5 ctrl write", {7'b0, ctrl_o}, 16'h003C);
    chk("R5 wiper untouched", {7'b0, wiper_o}, 16'h0100);
    xfer(mk(4'h4, 2'b11, 1'b0, 9'h000), 16, so);
    chk("R5 ctrl read", so, {7'h7F, 9'h03C});

    // R6 illegal address
    xfer(mk(4'h1, 2'b00, 1'b0, 9'h011), 16, so);
    chk("R6 bad addr sdo", so, 16'hFC00);
    chk("R6 bad addr no write", {7'b0, wiper_o}, 16'h0100);

    // R6 R7 illegal pair then a write in the same window
    cs_open();
    send_bits(mk(4'h4, 2'b01, 1'b0, 9'h000), 8, so);
    send_bits(mk(4'h0, 2'b00, 1'b0, 9'h033), 16, o2);
    cs_close();
    chk("R6 bad pair status", {so[15:8], 8'h00}, 16'hFC00);
    chk("R7 locked sdo", o2, 16'h0000);
    chk("R7 locked no write", {7'b0, wiper_o}, 16'h0100);
    chk("R7 ctrl unchanged", {7'b0, ctrl_o}, 16'h003C);
    xfer(mk(4'h0, 2'b00, 1'b0, 9'h033), 16, so);
    chk("R7 cleared on release", {7'b0, wiper_o}, 16'h0033);

    // R8 truncated commands
    xfer(mk(4'h0, 2'b00, 1'b0, 9'h0AA), 12, so);
    chk("R8 partial write dropped", {7'b0, wiper_o}, 16'h0033);
    xfer(mk(4'h0, 2'b01, 1'b0, 9'h000), 5, so);
    chk("R8 partial inc dropped", {7'b0, wiper_o}, 16'h0033);
    xfer(mk(4'h0, 2'b00, 1'b0, 9'h011), 16, so);
    chk("R8 realigned after abort", {7'b0, wiper_o}, 16'h0011);

    // R9 back to back, with a trailing partial increment
    cs_open();
    send_bits(mk(4'h0, 2'b01, 1'b0, 9'h000), 8, so);
    send_bits(mk(4'h0, 2'b01, 1'b0, 9'h000), 8, so);
    chk("R9 two incs", {7'b0, wiper_o}, 16'h0013);
    send_bits(mk(4'h0, 2'b00, 1'b0, 9'h020), 16, so);
    send_bits(mk(4'h0, 2'b10, 1'b0, 9'h000), 8, so);
    send_bits(mk(4'h0, 2'b11, 1'b0, 9'h000), 16, so);
    chk("R9 readback in window", so, {7'h7F, 9'h01F});
    send_bits(mk(4'h0, 2'b01, 1'b0, 9'h000), 4, so);
    cs_close();
    chk("R9 sequence result", {7'b0, wiper_o}, 16'h001F);

    // R10 clocking with chip select high
    oe_seen = 1'b0;
    for (int i = 0; i < 16; i++) begin
      spi_sdi = mk(4'h0, 2'b00, 1'b0, 9'h0AA) >> (15-i);
      wait_clk(HALF);
      oe_seen = oe_seen | spi_sdo_oe;
      spi_sck = 1;
      wait_clk(HALF);
      spi_sck = 0;
    end
    wait_clk(HALF);
    chk("R10 idle no write", {7'b0, wiper_o}, 16'h001F);
    chk("R10 oe low when idle", {15'b0, oe_seen}, 16'h0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule